// File: doc/BRIEF.md
# Prescaled Reload Timer

This block is a general-purpose up/down counter driven by a programmable clock divider. A small prescaler counts system clock cycles and emits a one-cycle tick every `cfg_prescale + 1` cycles. Each tick advances the main counter by one, in the direction set by configuration.

When counting up, the counter normally returns to zero on reaching the programmed reload value. In free-run mode it ignores the reload value and wraps only at full scale. When counting down, it reloads the programmed value after reaching zero. Every wrap or reload event sets a sticky pending flag. A mask bit gates that flag onto the interrupt line, and software clears it by pulsing a strobe.

The counter value and the running prescaler count are both visible at all times. The tick is exported so that other units can pace themselves on it. Counting happens only while both the enable and the clock-enable configuration bits are high. Clearing either one freezes the counter and the prescaler where they stand.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, `count_val`, `presc_val` and `irq` are all zero, and no interrupt is pending.
- R2: While running, `presc_val` steps 0, 1, … up to `cfg_prescale`. `tick` is high in the cycle where `presc_val` is at least `cfg_prescale`, and the prescaler returns to 0 at that edge. With `cfg_prescale = P`, this gives one tick every P+1 cycles.
- R3: With `cfg_count_down = 0` and `cfg_free_run = 0`, each tick increments the counter. A tick that finds the counter at or above `cfg_reload` returns it to 0 instead, and that tick is a wrap event.
- R4: With `cfg_count_down = 0` and `cfg_free_run = 1`, the counter increments past `cfg_reload`. It wraps to 0 only on a tick that finds it at the all-ones maximum, and that tick is a wrap event.
- R5: `cfg_free_run` has no effect while `cfg_count_down = 1`.
- R6: With `cfg_count_down = 1`, each tick decrements the counter. A tick that finds it at 0 loads `cfg_reload` instead, and that tick is a reload event.
- R7: Each wrap or reload event sets a sticky pending flag. `irq` equals the pending flag ANDed with `cfg_irq_unmask`, so a masked event appears on `irq` as soon as the mask bit is set to 1.
- R8: A one-cycle `irq_clear` pulse clears the pending flag at the next edge. If a wrap or reload event occurs in the same cycle, the flag stays set.
- R9: The block counts only while both `cfg_enable` and `cfg_clk_on` are 1. Otherwise `count_val` and `presc_val` hold their values, and counting resumes from them once both bits are 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Timer enable |
| cfg_clk_on | input | 1 | Timer clock enable |
| cfg_count_down | input | 1 | 1 = count down, 0 = count up |
| cfg_free_run | input | 1 | Wrap at full scale instead of the reload value (up-count only) |
| cfg_irq_unmask | input | 1 | 1 lets the pending flag reach `irq` |
| cfg_reload | input | CNT_W | Reload / wrap value |
| cfg_prescale | input | PRE_W | Divide ratio minus one |
| irq_clear | input | 1 | Clears the pending flag |
| count_val | output | CNT_W | Live counter value |
| presc_val | output | PRE_W | Live prescaler count |
| tick | output | 1 | Count strobe, one clock wide |
| irq | output | 1 | Masked interrupt |

## Verification
`tick` and `irq` are combinational from state and configuration, so both are due in the same cycle as the state or mask change that causes them. `count_val`, `presc_val` and the pending flag change one edge after a tick or a clear. The bench changes inputs only on falling edges. Its reference model steps on the rising edge from those same inputs, and every output is compared against the model on the next falling edge. Directed checks sample at that same point: a wrap one edge after the tick that finds the limit, a clear one edge after its strobe, and a freeze on the first edge after the enable falls.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_clk_on,
  input  logic             cfg_count_down,
  input  logic             cfg_free_run,
  input  logic             cfg_irq_unmask,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic             irq_clear,
  output logic [CNT_W-1:0] count_val,
  output logic [PRE_W-1:0] presc_val,
  output logic             tick,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             running, up_wrap, dn_wrap, wrap_evt, pending;
  logic [CNT_W-1:0] cnt_nxt;

  assign running  = cfg_enable & cfg_clk_on;
  assign tick     = running && (presc_val >= cfg_prescale);
  assign up_wrap  = cfg_free_run ? (count_val == CNT_MAX) : (count_val >= cfg_reload);
  assign dn_wrap  = (count_val == '0);
  assign wrap_evt = tick && (cfg_count_down ? dn_wrap : up_wrap);
  assign irq      = pending & cfg_irq_unmask;

  always_comb begin
    if (cfg_count_down) cnt_nxt = dn_wrap ? cfg_reload : count_val - 1'b1;
    else                cnt_nxt = up_wrap ? '0 : count_val + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       presc_val <= '0;
    else if (tick)    presc_val <= '0;
    else if (running) presc_val <= presc_val + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_val <= '0;
    else if (tick) count_val <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending <= 1'b0;
    else if (wrap_evt)  pending <= 1'b1;
    else if (irq_clear) pending <= 1'b0;
  end
endmodule

// File: rtl/prescaled_timer_checks.sv
module prescaled_timer_checks #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             cfg_clk_on,
  input logic             cfg_count_down,
  input logic             cfg_free_run,
  input logic             cfg_irq_unmask,
  input logic [CNT_W-1:0] cfg_reload,
  input logic [PRE_W-1:0] cfg_prescale,
  input logic             irq_clear,
  input logic [CNT_W-1:0] count_val,
  input logic [PRE_W-1:0] presc_val,
  input logic             tick,
  input logic             irq
);
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_enable && cfg_clk_on) |=> $stable(count_val) && $stable(presc_val));

  assert_tick_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cfg_enable && cfg_clk_on));

  assert_presc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_clk_on && !tick) |=> presc_val == PRE_W'($past(presc_val) + 1'b1));

  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_count_down && !cfg_free_run && count_val >= cfg_reload) |=> count_val == '0);

  assert_free_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_count_down && cfg_free_run && count_val != '1) |=>
      count_val == CNT_W'($past(count_val) + 1'b1));

  assert_down_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg_count_down && count_val == '0) |=> count_val == $past(cfg_reload));

  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_irq_unmask);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !tick) |=> !irq);
endmodule

bind prescaled_timer prescaled_timer_checks #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_clk_on(cfg_clk_on),
  .cfg_count_down(cfg_count_down), .cfg_free_run(cfg_free_run),
  .cfg_irq_unmask(cfg_irq_unmask), .cfg_reload(cfg_reload), .cfg_prescale(cfg_prescale),
  .irq_clear(irq_clear), .count_val(count_val), .presc_val(presc_val),
  .tick(tick), .irq(irq)
);

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;
  localparam int CW = 8;
  localparam int PW = 5;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, ce = 0, down = 0, free = 0, unmask = 0, clr = 0;
  logic [CW-1:0] reload = '0;
  logic [PW-1:0] presc = '0;
  logic [CW-1:0] count_val;
  logic [PW-1:0] presc_val;
  logic tick, irq;

  int total = 0, bad = 0;
  int m_cnt = 0, m_pre = 0, m_pend = 0;
  string req = "R1";

  always #2.5 clk = ~clk;

  prescaled_timer #(.CNT_W(CW), .PRE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_clk_on(ce),
    .cfg_count_down(down), .cfg_free_run(free), .cfg_irq_unmask(unmask),
    .cfg_reload(reload), .cfg_prescale(presc), .irq_clear(clr),
    .count_val(count_val), .presc_val(presc_val), .tick(tick), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_pend = 0;
    end else begin
      int ev;
      ev = 0;
      if (en && ce) begin
        if (m_pre >= int'(presc)) begin
          m_pre = 0;
          if (down) begin
            if (m_cnt == 0) begin m_cnt = int'(reload); ev = 1; end
            else m_cnt = m_cnt - 1;
          end else if (free) begin
            if (m_cnt == MAXV) begin m_cnt = 0; ev = 1; end
            else m_cnt = m_cnt + 1;
          end else begin
            if (m_cnt >= int'(reload)) begin m_cnt = 0; ev = 1; end
            else m_cnt = m_cnt + 1;
          end
        end else m_pre = m_pre + 1;
      end
      if (ev != 0) m_pend = 1;
      else if (clr) m_pend = 0;
    end
  end

  task automatic check(input bit ok, input string r, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic cyc();
    int etick, eirq;
    @(negedge clk);
    etick = (en && ce && m_pre >= int'(presc)) ? 1 : 0;
    eirq  = (m_pend != 0 && unmask) ? 1 : 0;
    check(int'(count_val) == m_cnt, req, "count_val", int'(count_val), m_cnt);
    check(int'(presc_val) == m_pre, req, "presc_val", int'(presc_val), m_pre);
    check(int'(tick) == etick, req, "tick", int'(tick), etick);
    check(int'(irq) == eirq, req, "irq", int'(irq), eirq);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    int ticks, maxseen, wrapped, saw_top, frz_c, frz_p;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(count_val == '0 && presc_val == '0 && irq == 1'b0, "R1", "reset outputs",
          int'(count_val) + int'(presc_val) + int'(irq), 0);
    rst_n = 1'b1;
    cyc();

    // R2 prescaler divide by 4
    req = "R2"; presc = 5'd3; reload = 8'd200; en = 1; ce = 1; unmask = 1;
    ticks = 0;
    for (int i = 0; i < 40; i++) begin cyc(); if (tick) ticks++; end
    check(ticks == 10, "R2", "ticks in 40 cycles", ticks, 10);

    // R3 up wrap at reload
    req = "R3"; presc = 5'd0; reload = 8'd5; clr = 1; cyc(); clr = 0;
    maxseen = 0; wrapped = 0;
    for (int i = 0; i < 30; i++) begin
      cyc();
      if (int'(count_val) > maxseen) maxseen = int'(count_val);
      if (count_val == 8'd0) wrapped++;
    end
    check(maxseen == 5, "R3", "max count with reload 5", maxseen, 5);
    check(wrapped >= 4, "R3", "returns to zero", wrapped, 4);

    // R4 free run passes reload, wraps at max
    req = "R4"; free = 1; maxseen = 0; wrapped = 0;
    for (int i = 0; i < 300; i++) begin
      cyc();
      if (int'(count_val) > maxseen) maxseen = int'(count_val);
    end
    check(maxseen == MAXV, "R4", "reaches full scale", maxseen, MAXV);

    // R6 down count reload
    req = "R6"; free = 0; down = 1; reload = 8'd7;
    saw_top = 0;
    for (int i = 0; i < 300; i++) begin cyc(); if (count_val == 8'd7) saw_top++; end
    check(saw_top >= 10, "R6", "reload value seen", saw_top, 10);

    // R5 free-run ignored in down mode
    req = "R5"; free = 1; maxseen = 0; saw_top = 0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (int'(count_val) > maxseen) maxseen = int'(count_val);
      if (count_val == 8'd7) saw_top++;
    end
    check(maxseen == 7, "R5", "down max with free-run", maxseen, 7);
    check(saw_top >= 4, "R5", "reload still used", saw_top, 4);

    // R7 mask
    req = "R7"; free = 0; down = 0; reload = 8'd3; unmask = 0;
    for (int i = 0; i < 12; i++) begin
      cyc();
      check(irq == 1'b0, "R7", "masked irq", int'(irq), 0);
    end
    unmask = 1; #0.1;
    check(irq == 1'b1, "R7", "irq on unmask", int'(irq), 1);

    // R8 clear without event, then clear with simultaneous event
    req = "R8"; en = 0;
    clr = 1; cyc(); clr = 0; cyc();
    check(irq == 1'b0, "R8", "cleared", int'(irq), 0);
    en = 1;
    for (int i = 0; i < 10 && count_val != 8'd3; i++) cyc();
    clr = 1; cyc(); clr = 0;
    check(irq == 1'b1, "R8", "event wins over clear", int'(irq), 1);
    clr = 1; cyc(); clr = 0; cyc();

    // R9 freeze and resume
    req = "R9"; presc = 5'd2; reload = 8'd100;
    for (int i = 0; i < 7; i++) cyc();
    frz_c = int'(count_val); frz_p = int'(presc_val);
    en = 0;
    for (int i = 0; i < 8; i++) cyc();
    check(int'(count_val) == frz_c, "R9", "count frozen (enable)", int'(count_val), frz_c);
    check(int'(presc_val) == frz_p, "R9", "presc frozen (enable)", int'(presc_val), frz_p);
    en = 1; ce = 0;
    for (int i = 0; i < 8; i++) cyc();
    check(int'(count_val) == frz_c, "R9", "count frozen (clk en)", int'(count_val), frz_c);
    ce = 1;
    for (int i = 0; i < 12; i++) cyc();
    check(int'(count_val) == frz_c + 4, "R9", "resumed count", int'(count_val), frz_c + 4);

    summary();
  end
endmodule